// File: doc/BRIEF.md
# 12-bit Coefficient Byte Packer

This block turns a run of polynomials, each holding `2*PAIRS` coefficients of 12 bits, into a byte stream. Each pair of coefficients becomes three bytes. The coefficients come from one of two external synchronous memories with a read latency of one cycle. The packed bytes go out as a write strobe, a byte offset and a data byte into a target buffer.

A pulse on `start` latches the number of polynomials and the source select. The block then works through every pair in a fixed cycle of four phases:

- phase 0 reads c0;
- phase 1 reads c1 and forms the first byte;
- phase 2 forms the second byte;
- phase 3 forms the third byte.

Only one memory read is issued per cycle. The upper bits of each coefficient are held in small registers until the byte that needs them is formed. Every write is registered, so it appears on the ports one cycle after the phase that produced it. When all bytes have left, `done` rises and stays high until the next start.

Top module: `coef12_packer`

## Requirements
- R1: While and after reset, `busy`, `done`, `wr_en`, `rd_en_a` and `rd_en_b` are all 0.
- R2: For each pair, exactly two reads are issued, in phases 0 and 1. The read address is poly*2*PAIRS + pair*2 + h, where h is 0 for c0 and 1 for c1. Across a run the addresses therefore step 0, 1, 2, … and total 2*PAIRS per polynomial.
- R3: The first byte of a pair (byte index 0) equals c0[7:0].
- R4: The second byte (byte index 1) equals {c1[3:0], c0[11:8]}, with c1's low nibble in bits 7:4.
- R5: The third byte (byte index 2) equals c1[11:4].
- R6: The write offset is poly*3*PAIRS + pair*3 + k, where k is the byte index. Writes come in bursts of exactly three consecutive cycles, separated by one cycle with no write, so the offsets step 0, 1, 2, … with no gaps.
- R7: A run issues exactly 3*PAIRS writes per polynomial.
- R8: `src_sel`=0 reads memory A through `rd_en_a`; `src_sel`=1 reads memory B through `rd_en_b`. The select is latched at start, so changing `src_sel` during a run has no effect, and the two read enables are never high together.
- R9: `busy` is high from the cycle after an accepted start until the run ends. `done` rises the cycle after the last write strobe, stays high with no reads or writes, and clears on the next start.
- R10: A `start` pulse while `busy` is high is ignored. The count, the select and the output stream are unchanged.
- R11: A start with `poly_count`=0 raises `done` one cycle later and issues no reads and no writes.
- R12: A `poly_count` above MAX_POLY is clamped to MAX_POLY polynomials.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted when not busy |
| src_sel | input | 1 | Source memory select (0 = A, 1 = B), latched at start |
| poly_count | input | POLY_W | Number of polynomials to pack (clamped to MAX_POLY) |
| rd_addr | output | RD_AW | Coefficient read address |
| rd_en_a | output | 1 | Read enable for memory A |
| rd_en_b | output | 1 | Read enable for memory B |
| rd_data_a | input | 12 | Memory A data, valid one cycle after the address |
| rd_data_b | input | 12 | Memory B data, valid one cycle after the address |
| wr_en | output | 1 | Byte write strobe (registered) |
| wr_off | output | OFF_W | Byte offset into the target buffer (registered) |
| wr_byte | output | 8 | Packed byte (registered) |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, held until next start |

## Verification
In phase 1 the block issues the read of c1 in the same cycle as it forms byte 0 from the c0 data that has just returned. In phase 2 it saves c1's high bits in the same cycle as it emits the merged byte. Any slip of one cycle in the read alignment therefore shows up in bytes 0 and 1. Every byte of runs on both sources is compared against values computed from the bench's own memory contents.

A second collision is a `start` pulse, with a different select and count, that arrives while a run is active. A change of `src_sel` in the middle of a run is a third. In both cases the bench judges the result by the read enables, the addresses and the full byte stream, all of which must stay exactly as for an undisturbed run.

// File: rtl/pkr_pkg.sv
package pkr_pkg;
  localparam int COEF_W = 12;
  localparam int BYTES_PER_PAIR = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FLUSH = 2'd2,
    ST_DONE  = 2'd3
  } pkr_state_e;

  typedef logic [1:0] pkr_phase_t;
endpackage

// File: rtl/pkr_seq.sv
module pkr_seq import pkr_pkg::*; #(
  parameter int PAIRS    = 128,
  parameter int MAX_POLY = 4,
  localparam int PAIR_W  = $clog2(PAIRS),
  localparam int POLY_W  = $clog2(MAX_POLY + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              src_sel,
  input  logic [POLY_W-1:0] poly_count,
  output logic              run_o,
  output pkr_phase_t        ph_o,
  output logic [PAIR_W-1:0] pair_o,
  output logic [POLY_W-1:0] poly_o,
  output logic              sel_o,
  output logic              busy_o,
  output logic              done_o
);
  pkr_state_e        state_q;
  logic [POLY_W-1:0] cnt_q;
  logic              sel_q;
  logic              last_pair;
  logic              last_poly;
  logic              accept;

  assign last_pair = (pair_o == PAIR_W'(PAIRS - 1));
  assign last_poly = (poly_o == cnt_q - 1'b1);
  assign accept    = start && (state_q == ST_IDLE || state_q == ST_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sel_q   <= 1'b0;
      ph_o    <= 2'd0;
      pair_o  <= '0;
      poly_o  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: begin
          if (accept) begin
            cnt_q   <= (poly_count > POLY_W'(MAX_POLY)) ? POLY_W'(MAX_POLY) : poly_count;
            sel_q   <= src_sel;
            ph_o    <= 2'd0;
            pair_o  <= '0;
            poly_o  <= '0;
            state_q <= (poly_count == '0) ? ST_DONE : ST_RUN;
          end
        end
        ST_RUN: begin
          ph_o <= ph_o + 2'd1;
          if (ph_o == 2'd3) begin
            if (last_pair) begin
              pair_o <= '0;
              if (last_poly) state_q <= ST_FLUSH;
              else           poly_o  <= poly_o + 1'b1;
            end else begin
              pair_o <= pair_o + 1'b1;
            end
          end
        end
        ST_FLUSH: state_q <= ST_DONE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign run_o  = (state_q == ST_RUN);
  assign busy_o = (state_q == ST_RUN) || (state_q == ST_FLUSH);
  assign done_o = (state_q == ST_DONE);
  assign sel_o  = sel_q;

  AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start && poly_count == '0) |=> (done_o && !busy_o)); // R11
  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start && poly_count != '0) |=> busy_o); // R9
  AST_SEL_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start) |=> $stable(sel_q)); // R10
  AST_CLAMP: assert property (@(posedge clk) disable iff (rst)
    run_o |-> (poly_o < POLY_W'(MAX_POLY))); // R12
endmodule

// File: rtl/pkr_rdport.sv
module pkr_rdport import pkr_pkg::*; #(
  parameter int PAIRS    = 128,
  parameter int MAX_POLY = 4,
  localparam int PAIR_W  = $clog2(PAIRS),
  localparam int POLY_W  = $clog2(MAX_POLY + 1),
  localparam int RD_AW   = $clog2(MAX_POLY * PAIRS * 2)
) (
  input  logic              run,
  input  pkr_phase_t        ph,
  input  logic [PAIR_W-1:0] pair,
  input  logic [POLY_W-1:0] poly,
  input  logic              sel,
  input  logic [COEF_W-1:0] rd_data_a,
  input  logic [COEF_W-1:0] rd_data_b,
  output logic [RD_AW-1:0]  rd_addr,
  output logic              rd_en_a,
  output logic              rd_en_b,
  output logic [COEF_W-1:0] coef
);
  localparam int COEFS_POLY = PAIRS * 2;

  logic fetch;
  logic half;

  assign fetch = run && (ph == 2'd0 || ph == 2'd1);
  assign half  = (ph == 2'd1);

  assign rd_addr = RD_AW'(poly) * RD_AW'(COEFS_POLY)
                 + RD_AW'(pair) * RD_AW'(2) + RD_AW'(half);

  assign rd_en_a = fetch && !sel;
  assign rd_en_b = fetch &&  sel;
  assign coef    = sel ? rd_data_b : rd_data_a;
endmodule

// File: rtl/pkr_pack.sv
module pkr_pack import pkr_pkg::*; #(
  parameter int PAIRS    = 128,
  parameter int MAX_POLY = 4,
  localparam int PAIR_W  = $clog2(PAIRS),
  localparam int POLY_W  = $clog2(MAX_POLY + 1),
  localparam int OFF_W   = $clog2(MAX_POLY * PAIRS * BYTES_PER_PAIR)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  pkr_phase_t        ph,
  input  logic [PAIR_W-1:0] pair,
  input  logic [POLY_W-1:0] poly,
  input  logic [COEF_W-1:0] coef,
  output logic              wr_en,
  output logic [OFF_W-1:0]  wr_off,
  output logic [7:0]        wr_byte
);
  localparam int BYTES_POLY = PAIRS * BYTES_PER_PAIR;

  logic [3:0]       c0_hi_q;
  logic [7:0]       c1_hi_q;
  logic [7:0]       byte_d;
  logic [OFF_W-1:0] off_d;
  logic             emit;

  assign emit = run && (ph != 2'd0);

  always_comb begin
    unique case (ph)
      2'd1:    byte_d = coef[7:0];
      2'd2:    byte_d = {coef[3:0], c0_hi_q};
      default: byte_d = c1_hi_q;
    endcase
  end

  assign off_d = OFF_W'(poly) * OFF_W'(BYTES_POLY)
               + OFF_W'(pair) * OFF_W'(BYTES_PER_PAIR)
               + OFF_W'(ph - 2'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      c0_hi_q <= '0;
      c1_hi_q <= '0;
      wr_en   <= 1'b0;
      wr_off  <= '0;
      wr_byte <= '0;
    end else begin
      if (run && ph == 2'd1) c0_hi_q <= coef[11:8];
      if (run && ph == 2'd2) c1_hi_q <= coef[11:4];
      wr_en <= emit;
      if (emit) begin
        wr_off  <= off_d;
        wr_byte <= byte_d;
      end
    end
  end

  AST_OFF_STEP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wr_en)) |-> (wr_off == $past(wr_off) + 1'b1)); // R6
  AST_BURST_END: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_en) |-> ($past(wr_off) % BYTES_PER_PAIR == 2)); // R6
  AST_FETCH_SILENT: assert property (@(posedge clk) disable iff (rst)
    (run && ph == 2'd0) |=> !wr_en); // R2
endmodule

// File: rtl/coef12_packer.sv
module coef12_packer import pkr_pkg::*; #(
  parameter int PAIRS    = 128,
  parameter int MAX_POLY = 4,
  localparam int PAIR_W  = $clog2(PAIRS),
  localparam int POLY_W  = $clog2(MAX_POLY + 1),
  localparam int RD_AW   = $clog2(MAX_POLY * PAIRS * 2),
  localparam int OFF_W   = $clog2(MAX_POLY * PAIRS * BYTES_PER_PAIR)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              src_sel,
  input  logic [POLY_W-1:0] poly_count,
  output logic [RD_AW-1:0]  rd_addr,
  output logic              rd_en_a,
  output logic              rd_en_b,
  input  logic [11:0]       rd_data_a,
  input  logic [11:0]       rd_data_b,
  output logic              wr_en,
  output logic [OFF_W-1:0]  wr_off,
  output logic [7:0]        wr_byte,
  output logic              busy,
  output logic              done
);
  logic              run;
  pkr_phase_t        ph;
  logic [PAIR_W-1:0] pair;
  logic [POLY_W-1:0] poly;
  logic              sel;
  logic [COEF_W-1:0] coef;

  pkr_seq #(.PAIRS(PAIRS), .MAX_POLY(MAX_POLY)) u_seq (
    .clk(clk), .rst(rst), .start(start), .src_sel(src_sel),
    .poly_count(poly_count), .run_o(run), .ph_o(ph), .pair_o(pair),
    .poly_o(poly), .sel_o(sel), .busy_o(busy), .done_o(done)
  );

  pkr_rdport #(.PAIRS(PAIRS), .MAX_POLY(MAX_POLY)) u_rdport (
    .run(run), .ph(ph), .pair(pair), .poly(poly), .sel(sel),
    .rd_data_a(rd_data_a), .rd_data_b(rd_data_b), .rd_addr(rd_addr),
    .rd_en_a(rd_en_a), .rd_en_b(rd_en_b), .coef(coef)
  );

  pkr_pack #(.PAIRS(PAIRS), .MAX_POLY(MAX_POLY)) u_pack (
    .clk(clk), .rst(rst), .run(run), .ph(ph), .pair(pair), .poly(poly),
    .coef(coef), .wr_en(wr_en), .wr_off(wr_off), .wr_byte(wr_byte)
  );

  AST_RD_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(rd_en_a && rd_en_b)); // R8
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    done |-> (!rd_en_a && !rd_en_b && !wr_en && !busy)); // R9
  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (!wr_en && !busy && !done)); // R1
endmodule

// File: tb/coef12_packer_bench.sv
module coef12_packer_bench;
  localparam int PAIRS = 128;
  localparam int MAXP  = 4;
  localparam int BPP   = PAIRS * 3;
  localparam int CPP   = PAIRS * 2;

  // vector: {src_sel, poly_count[2:0], flip_sel_mid_run, start_pulse_mid_run}
  localparam logic [5:0] VEC [0:5] = '{
    6'b0_001_00, 6'b1_010_00, 6'b0_100_00,
    6'b1_001_10, 6'b0_010_01, 6'b1_111_00
  };

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, src_sel = 1'b0;
  logic [2:0]  poly_count = '0;
  logic [9:0]  rd_addr;
  logic        rd_en_a, rd_en_b, wr_en, busy, done;
  logic [11:0] rd_data_a = '0, rd_data_b = '0;
  logic [10:0] wr_off;
  logic [7:0]  wr_byte;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int wr_cnt = 0, rd_cnt = 0, runlen = 0, exp_total = 0;
  logic cur_sel = 1'b0, prev_wr = 1'b0, prev_done = 1'b0;

  always #10 clk = ~clk;

  coef12_packer u_coef12_packer (
    .clk(clk), .rst(rst), .start(start), .src_sel(src_sel),
    .poly_count(poly_count), .rd_addr(rd_addr), .rd_en_a(rd_en_a),
    .rd_en_b(rd_en_b), .rd_data_a(rd_data_a), .rd_data_b(rd_data_b),
    .wr_en(wr_en), .wr_off(wr_off), .wr_byte(wr_byte),
    .busy(busy), .done(done)
  );

  function automatic logic [11:0] coef(input logic s, input int idx);
    int v;
    v = idx * 149 + (s ? 1777 : 0) + 11;
    return v[11:0];
  endfunction

  always @(posedge clk) begin
    if (rd_en_a) rd_data_a <= coef(1'b0, int'(rd_addr));
    if (rd_en_b) rd_data_b <= coef(1'b1, int'(rd_addr));
  end

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); #5;
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (rd_en_a || rd_en_b) begin
        chk(rd_en_b == cur_sel && !(rd_en_a && rd_en_b), "R8 read source", rd_en_b, cur_sel);
        chk(int'(rd_addr) == rd_cnt, "R2 read address", rd_addr, rd_cnt);
        rd_cnt++;
      end
      if (wr_en) begin
        int p, r, pr, k;
        logic [11:0] c0, c1;
        logic [7:0] eb;
        p = wr_cnt / BPP; r = wr_cnt % BPP; pr = r / 3; k = r % 3;
        c0 = coef(cur_sel, p * CPP + pr * 2);
        c1 = coef(cur_sel, p * CPP + pr * 2 + 1);
        chk(int'(wr_off) == wr_cnt, "R6 offset", wr_off, wr_cnt);
        if (k == 0) begin eb = c0[7:0];           chk(wr_byte == eb, "R3 byte0", wr_byte, eb); end
        else if (k == 1) begin eb = {c1[3:0], c0[11:8]}; chk(wr_byte == eb, "R4 byte1", wr_byte, eb); end
        else begin eb = c1[11:4];                 chk(wr_byte == eb, "R5 byte2", wr_byte, eb); end
        chk(!done, "R9 done low while writing", done, 0);
        wr_cnt++; runlen++;
      end else if (runlen > 0) begin
        chk(runlen == 3, "R6 burst length", runlen, 3);
        runlen = 0;
      end
      if (done && !prev_done && exp_total > 0)
        chk(prev_wr && wr_cnt == exp_total, "R9 done after last write", wr_cnt, exp_total);
      prev_wr   = wr_en;
      prev_done = done;
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R9 actual=%0d expected<150000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) step();
    chk(!busy && !done && !wr_en && !rd_en_a && !rd_en_b, "R1 in reset", {busy, done, wr_en}, 0);
    rst = 1'b0;
    step();
    chk(!busy && !done && !wr_en && !rd_en_a && !rd_en_b, "R1 after reset", {busy, done, wr_en}, 0);

    for (int i = 0; i < 6; i++) begin
      logic [5:0] v;
      int np, n;
      v = VEC[i];
      np = (int'(v[4:2]) > MAXP) ? MAXP : int'(v[4:2]);
      cur_sel = v[5]; exp_total = np * BPP;
      wr_cnt = 0; rd_cnt = 0; runlen = 0;
      src_sel = v[5]; poly_count = v[4:2]; start = 1'b1;
      step();
      start = 1'b0;
      chk(busy && !done, "R9 busy after start", busy, 1);
      n = 0;
      while (!done && n < 6000) begin
        step(); n++;
        if (v[1] && n == 100) src_sel = ~v[5];          // R8 mid-run select change
        if (v[0] && n == 200) begin                      // R10 start while busy
          src_sel = ~v[5]; poly_count = 3'd1; start = 1'b1;
          step(); n++; start = 1'b0;
        end
      end
      chk(wr_cnt == exp_total, "R7 write count", wr_cnt, exp_total);
      chk(rd_cnt == np * CPP, "R2 read count", rd_cnt, np * CPP);
      if (v[4:2] > 3'd4) chk(wr_cnt == MAXP * BPP, "R12 clamp", wr_cnt, MAXP * BPP);
      if (v[0]) chk(wr_cnt == exp_total, "R10 start ignored", wr_cnt, exp_total);
      repeat (3) step();
      chk(done && !busy && !wr_en, "R9 done held", done, 1);
    end

    exp_total = 0; wr_cnt = 0; rd_cnt = 0;
    poly_count = 3'd0; src_sel = 1'b0; start = 1'b1;
    step();
    start = 1'b0;
    chk(done && !busy, "R11 zero count done", done, 1);
    repeat (4) step();
    chk(wr_cnt == 0 && rd_cnt == 0, "R11 no traffic", wr_cnt + rd_cnt, 0);

    cur_sel = 1'b1; exp_total = BPP; wr_cnt = 0; rd_cnt = 0; runlen = 0;
    poly_count = 3'd1; src_sel = 1'b1; start = 1'b1;
    step();
    start = 1'b0;
    chk(!done && busy, "R9 done clears on restart", done, 0);
    for (int n = 0; n < 1000 && !done; n++) step();
    chk(wr_cnt == BPP, "R7 restart write count", wr_cnt, BPP);

    finish_run();
  end
endmodule